// File: doc/BRIEF.md
# Lockable GPIO Pad Configuration Bank

This block holds the pad settings for one port of general-purpose pins. For each pin it stores the direction, the digital enable, the analog select, the peripheral-function enable and a 4-bit function number. It also stores the pull-up and pull-down enables, the open-drain select, one of three drive strengths and a slew-control bit. A word-addressed register bus writes these settings, and they go out on per-pin configuration outputs. The outputs feed the pad ring and the peripheral multiplexer.

Two pairs of settings keep themselves consistent in hardware. The pull-up and pull-down enables exclude each other. Setting any one drive strength deselects the other two. Some pins leave reset with a peripheral function attached, such as a debug port or a non-maskable interrupt. These special pins are guarded by a commit mask. The mask itself can only be rewritten after a 32-bit key has been written to a lock register. While a pin's commit bit is 0, its sensitive settings cannot be changed.

Top module: `padcfg_bank`

## Requirements
- R1: Reset state. Every pin is an input (direction 0) with the digital path enabled. Analog select, pulls and open drain are off, and the 2 mA drive is selected. Slew control is 0 and every function number is 0. The lock is closed. The commit mask and the function-enable register both reset from the SPECIAL_PINS parameter: the commit mask is its complement, and the function enable equals it. With the default value 8'h09, special pins 0 and 3 reset with commit 0 and function enable 1.
- R2: Writing a pull register sets each written 1 and clears the same pin in the other pull register. The pull-up register is at byte offset 0x14 and the pull-down register is at 0x18.
- R3: There are three drive registers: 2 mA at 0x20, 4 mA at 0x24 and 8 mA at 0x28. Writing one of them loads it with the written value and clears every written 1 from the other two.
- R4: The slew register is at 0x2C. Output pad_slew for a pin is 1 only when its slew bit and its 8 mA drive bit are both 1.
- R5: The function-number register is at 0x10. It holds pin n's 4-bit number at bits [4n+3:4n], and it drives that value on pad_fsel.
- R6: The lock register is at 0x30. Writing 32'h4C4F434B to it opens the lock, and writing any other value closes it. A read returns 1 while the lock is closed and 0 while it is open. The commit mask is at 0x34. A write to it takes effect only while the lock is open.
- R7: For a pin whose commit bit is 0, writes to its digital enable (0x04), function enable (0x0C), pull-up and pull-down bits are ignored. This includes the pull cross-clear.
- R8: Only bits [NPINS-1:0] of the per-pin registers are stored, and the upper read bits are 0. A write with bus_addr[1:0] not equal to 0 is ignored. Offsets 0x38 and 0x3C read 0.
- R9: Direction (0x00), analog select (0x08) and open drain (0x1C) are never protected. They are loaded directly from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_dir | output | 8 | 1 = output |
| pad_den | output | 8 | Digital path enable |
| pad_ana | output | 8 | Analog select |
| pad_afen | output | 8 | Peripheral function enable |
| pad_fsel | output | 32 | Per-pin function numbers, 4 bits each |
| pad_pu | output | 8 | Pull-up enable |
| pad_pd | output | 8 | Pull-down enable |
| pad_od | output | 8 | Open-drain select |
| pad_drv2 | output | 8 | 2 mA drive select |
| pad_drv4 | output | 8 | 4 mA drive select |
| pad_drv8 | output | 8 | 8 mA drive select |
| pad_slew | output | 8 | Effective slew control |

## Verification
The checker asserts four properties on every clock. The two pull enables never overlap. No pin ever has more than one drive strength selected. Slew never appears without 8 mA drive. A pin with commit 0 never sees its protected bits change. It also checks that the commit mask stays still while the lock is closed and that the lock opens after a matching key write.

Some behaviour only the bench scenarios can show. These include the exact value each register returns after a sequence of writes and the function-field layout. They also include the lock reading back as 1 again after a wrong key, the dropping of misaligned writes, and the restoration of the commit mask by a reset in the middle of a run.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;

  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int NREG   = 14;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h4C4F_434B;

  typedef enum logic [IDX_W-1:0] {
    RG_DIR    = 4'd0,
    RG_DEN    = 4'd1,
    RG_ANA    = 4'd2,
    RG_AFEN   = 4'd3,
    RG_FSEL   = 4'd4,
    RG_PU     = 4'd5,
    RG_PD     = 4'd6,
    RG_OD     = 4'd7,
    RG_D2     = 4'd8,
    RG_D4     = 4'd9,
    RG_D8     = 4'd10,
    RG_SLEW   = 4'd11,
    RG_KEY    = 4'd12,
    RG_COMMIT = 4'd13
  } reg_sel_e;

  // Returns 1 when a word holds the unlock key.
  function automatic logic key_matches(input logic [DATA_W-1:0] word);
    return word == UNLOCK_KEY;
  endfunction

endpackage

// File: rtl/padcfg_keylock.sv
module padcfg_keylock #(
  parameter int NPINS = 8,
  parameter logic [NPINS-1:0] COMMIT_RST = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      key_we,
  input  logic                      commit_we,
  input  logic [padcfg_pkg::DATA_W-1:0] wdata,
  output logic                      locked,
  output logic [NPINS-1:0]          commit,
  output logic                      key_unlock_ev,
  output logic                      commit_blocked
);

  logic key_hit;

  assign key_hit        = padcfg_pkg::key_matches(wdata);
  assign key_unlock_ev  = key_we && key_hit;
  assign commit_blocked = commit_we && locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b1;
    end else if (key_we) begin
      locked <= !key_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit <= COMMIT_RST;
    end else if (commit_we && !locked) begin
      commit <= wdata[NPINS-1:0];
    end
  end

endmodule

// File: rtl/padcfg_pinbank.sv
module padcfg_pinbank
  import padcfg_pkg::*;
#(
  parameter int NPINS = 8,
  parameter logic [NPINS-1:0] SPECIAL_PINS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREG-1:0]  wr_sel,
  input  logic [NPINS-1:0] wd,
  input  logic [NPINS-1:0] commit,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] den_q,
  output logic [NPINS-1:0] ana_q,
  output logic [NPINS-1:0] afen_q,
  output logic [NPINS-1:0] pu_q,
  output logic [NPINS-1:0] pd_q,
  output logic [NPINS-1:0] od_q,
  output logic [NPINS-1:0] d2_q,
  output logic [NPINS-1:0] d4_q,
  output logic [NPINS-1:0] d8_q,
  output logic [NPINS-1:0] slew_q,
  output logic [NPINS-1:0] dropped
);

  // Keep old bits where allow is 0, take new bits where allow is 1.
  function automatic logic [NPINS-1:0] guarded(input logic [NPINS-1:0] old_v,
                                               input logic [NPINS-1:0] new_v,
                                               input logic [NPINS-1:0] allow);
    return (old_v & ~allow) | (new_v & allow);
  endfunction

  // Clear the bits that another register has just claimed.
  function automatic logic [NPINS-1:0] strip(input logic [NPINS-1:0] old_v,
                                             input logic [NPINS-1:0] claim);
    return old_v & ~claim;
  endfunction

  logic prot_wr;
  logic [NPINS-1:0] claim_ok;
  logic unused_sel;

  assign prot_wr    = wr_sel[RG_DEN] | wr_sel[RG_AFEN] | wr_sel[RG_PU] | wr_sel[RG_PD];
  assign claim_ok   = wd & commit;
  assign dropped    = prot_wr ? (wd ^ guarded(wd, '0, ~commit)) & ~commit : '0;
  assign unused_sel = ^{wr_sel[RG_FSEL], wr_sel[RG_KEY], wr_sel[RG_COMMIT]};

  // Unprotected plain registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      ana_q  <= '0;
      od_q   <= '0;
      slew_q <= '0;
    end else begin
      if (wr_sel[RG_DIR])  dir_q  <= wd;
      if (wr_sel[RG_ANA])  ana_q  <= wd;
      if (wr_sel[RG_OD])   od_q   <= wd;
      if (wr_sel[RG_SLEW]) slew_q <= wd;
    end
  end

  // Protected enables
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      den_q  <= '1;
      afen_q <= SPECIAL_PINS;
    end else begin
      if (wr_sel[RG_DEN])  den_q  <= guarded(den_q, wd, commit);
      if (wr_sel[RG_AFEN]) afen_q <= guarded(afen_q, wd, commit);
    end
  end

  // Mutually exclusive pulls, protected
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pu_q <= '0;
      pd_q <= '0;
    end else if (wr_sel[RG_PU]) begin
      pu_q <= guarded(pu_q, wd, commit);
      pd_q <= strip(pd_q, claim_ok);
    end else if (wr_sel[RG_PD]) begin
      pd_q <= guarded(pd_q, wd, commit);
      pu_q <= strip(pu_q, claim_ok);
    end
  end

  // One-of-three drive strength
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d2_q <= '1;
      d4_q <= '0;
      d8_q <= '0;
    end else if (wr_sel[RG_D2]) begin
      d2_q <= wd;
      d4_q <= strip(d4_q, wd);
      d8_q <= strip(d8_q, wd);
    end else if (wr_sel[RG_D4]) begin
      d4_q <= wd;
      d2_q <= strip(d2_q, wd);
      d8_q <= strip(d8_q, wd);
    end else if (wr_sel[RG_D8]) begin
      d8_q <= wd;
      d2_q <= strip(d2_q, wd);
      d4_q <= strip(d4_q, wd);
    end
  end

endmodule

// File: rtl/padcfg_bank.sv
module padcfg_bank
  import padcfg_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int FSEL_W = 4,
  parameter int ADDR_W = 6,
  parameter logic [NPINS-1:0] SPECIAL_PINS = 8'h09
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NPINS-1:0]         pad_dir,
  output logic [NPINS-1:0]         pad_den,
  output logic [NPINS-1:0]         pad_ana,
  output logic [NPINS-1:0]         pad_afen,
  output logic [FSEL_W*NPINS-1:0]  pad_fsel,
  output logic [NPINS-1:0]         pad_pu,
  output logic [NPINS-1:0]         pad_pd,
  output logic [NPINS-1:0]         pad_od,
  output logic [NPINS-1:0]         pad_drv2,
  output logic [NPINS-1:0]         pad_drv4,
  output logic [NPINS-1:0]         pad_drv8,
  output logic [NPINS-1:0]         pad_slew
);

  localparam int FSEL_TOT = FSEL_W * NPINS;

  logic [IDX_W-1:0]   reg_idx;
  logic               aligned;
  logic [NREG-1:0]    wr_sel;
  logic               lock_state;
  logic [NPINS-1:0]   commit_q;
  logic               key_unlock_ev;
  logic               commit_blocked;
  logic [NPINS-1:0]   prot_dropped;
  logic [NPINS-1:0]   slew_raw;
  logic [FSEL_TOT-1:0] fsel_q;

  assign reg_idx = bus_addr[IDX_W+1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  // Write decode: one strobe per register
  for (genvar r = 0; r < NREG; r++) begin : g_dec
    assign wr_sel[r] = bus_we && aligned && (reg_idx == IDX_W'(r));
  end

  padcfg_keylock #(
    .NPINS      (NPINS),
    .COMMIT_RST (~SPECIAL_PINS)
  ) u_keylock (
    .clk            (clk),
    .rst_n          (rst_n),
    .key_we         (wr_sel[RG_KEY]),
    .commit_we      (wr_sel[RG_COMMIT]),
    .wdata          (bus_wdata),
    .locked         (lock_state),
    .commit         (commit_q),
    .key_unlock_ev  (key_unlock_ev),
    .commit_blocked (commit_blocked)
  );

  padcfg_pinbank #(
    .NPINS        (NPINS),
    .SPECIAL_PINS (SPECIAL_PINS)
  ) u_pinbank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wd      (bus_wdata[NPINS-1:0]),
    .commit  (commit_q),
    .dir_q   (pad_dir),
    .den_q   (pad_den),
    .ana_q   (pad_ana),
    .afen_q  (pad_afen),
    .pu_q    (pad_pu),
    .pd_q    (pad_pd),
    .od_q    (pad_od),
    .d2_q    (pad_drv2),
    .d4_q    (pad_drv4),
    .d8_q    (pad_drv8),
    .slew_q  (slew_raw),
    .dropped (prot_dropped)
  );

  // Per-pin function fields and slew gating
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fsel_q[FSEL_W*p +: FSEL_W] <= '0;
      end else if (wr_sel[RG_FSEL]) begin
        fsel_q[FSEL_W*p +: FSEL_W] <= bus_wdata[(FSEL_W*p) % DATA_W +: FSEL_W];
      end
    end
    assign pad_slew[p] = slew_raw[p] & pad_drv8[p];
  end

  assign pad_fsel = fsel_q;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (reg_idx)
      RG_DIR:    bus_rdata[NPINS-1:0] = pad_dir;
      RG_DEN:    bus_rdata[NPINS-1:0] = pad_den;
      RG_ANA:    bus_rdata[NPINS-1:0] = pad_ana;
      RG_AFEN:   bus_rdata[NPINS-1:0] = pad_afen;
      RG_FSEL:   bus_rdata = DATA_W'(fsel_q);
      RG_PU:     bus_rdata[NPINS-1:0] = pad_pu;
      RG_PD:     bus_rdata[NPINS-1:0] = pad_pd;
      RG_OD:     bus_rdata[NPINS-1:0] = pad_od;
      RG_D2:     bus_rdata[NPINS-1:0] = pad_drv2;
      RG_D4:     bus_rdata[NPINS-1:0] = pad_drv4;
      RG_D8:     bus_rdata[NPINS-1:0] = pad_drv8;
      RG_SLEW:   bus_rdata[NPINS-1:0] = slew_raw;
      RG_KEY:    bus_rdata[0] = lock_state;
      RG_COMMIT: bus_rdata[NPINS-1:0] = commit_q;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/padcfg_bank_checker.sv
module padcfg_bank_checker #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             locked,
  input logic [NPINS-1:0] commit,
  input logic             key_unlock_ev,
  input logic             commit_blocked,
  input logic [NPINS-1:0] pad_den,
  input logic [NPINS-1:0] pad_afen,
  input logic [NPINS-1:0] pad_pu,
  input logic [NPINS-1:0] pad_pd,
  input logic [NPINS-1:0] pad_drv2,
  input logic [NPINS-1:0] pad_drv4,
  input logic [NPINS-1:0] pad_drv8,
  input logic [NPINS-1:0] pad_slew
);

  p_pull_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  p_drive_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_drv2 & pad_drv4) | (pad_drv2 & pad_drv8) | (pad_drv4 & pad_drv8)) == '0);

  p_slew_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_slew & ~pad_drv8) == '0);

  p_key_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_unlock_ev |=> !locked);

  p_commit_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(commit));

  p_blocked_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_blocked |=> $stable(commit));

  p_protect_den_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_den ^ $past(pad_den)) & ~$past(commit)) == '0);

  p_protect_afen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_afen ^ $past(pad_afen)) & ~$past(commit)) == '0);

  p_protect_pu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu ^ $past(pad_pu)) & ~$past(commit)) == '0);

  p_protect_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pd ^ $past(pad_pd)) & ~$past(commit)) == '0);

endmodule

bind padcfg_bank padcfg_bank_checker #(.NPINS(NPINS)) u_padcfg_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .locked         (lock_state),
  .commit         (commit_q),
  .key_unlock_ev  (key_unlock_ev),
  .commit_blocked (commit_blocked),
  .pad_den        (pad_den),
  .pad_afen       (pad_afen),
  .pad_pu         (pad_pu),
  .pad_pd         (pad_pd),
  .pad_drv2       (pad_drv2),
  .pad_drv4       (pad_drv4),
  .pad_drv8       (pad_drv8),
  .pad_slew       (pad_slew)
);

// File: tb/padcfg_bank_bench.sv
module padcfg_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_dir, pad_den, pad_ana, pad_afen, pad_pu, pad_pd, pad_od;
  logic [7:0]  pad_drv2, pad_drv4, pad_drv8, pad_slew;
  logic [31:0] pad_fsel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  padcfg_bank u_padcfg_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_dir(pad_dir), .pad_den(pad_den), .pad_ana(pad_ana), .pad_afen(pad_afen),
    .pad_fsel(pad_fsel), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_od(pad_od),
    .pad_drv2(pad_drv2), .pad_drv4(pad_drv4), .pad_drv8(pad_drv8), .pad_slew(pad_slew)
  );

  // Vector: {is_read, req number, byte address, data or expected value}
  localparam int NV = 41;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 4'd2, 6'h14, 32'h0000_00FF},  // R2 pull-up all, special pins blocked
    {1'b1, 4'd7, 6'h14, 32'h0000_00F6},  // R7
    {1'b0, 4'd2, 6'h18, 32'h0000_0030},
    {1'b1, 4'd2, 6'h14, 32'h0000_00C6},  // R2 cross-clear
    {1'b1, 4'd2, 6'h18, 32'h0000_0030},
    {1'b0, 4'd3, 6'h24, 32'h0000_000F},
    {1'b1, 4'd3, 6'h20, 32'h0000_00F0},  // R3
    {1'b1, 4'd3, 6'h24, 32'h0000_000F},
    {1'b0, 4'd3, 6'h28, 32'h0000_0003},
    {1'b1, 4'd3, 6'h24, 32'h0000_000C},
    {1'b1, 4'd3, 6'h28, 32'h0000_0003},
    {1'b0, 4'd5, 6'h10, 32'h1234_5678},
    {1'b1, 4'd5, 6'h10, 32'h1234_5678},  // R5
    {1'b0, 4'd9, 6'h00, 32'h0000_00FF},
    {1'b1, 4'd9, 6'h00, 32'h0000_00FF},  // R9 direction not protected
    {1'b0, 4'd7, 6'h04, 32'h0000_0000},
    {1'b1, 4'd7, 6'h04, 32'h0000_0009},  // R7 den kept on special pins
    {1'b0, 4'd7, 6'h0C, 32'h0000_0000},
    {1'b1, 4'd7, 6'h0C, 32'h0000_0009},
    {1'b0, 4'd9, 6'h08, 32'h0000_00A5},
    {1'b1, 4'd9, 6'h08, 32'h0000_00A5},
    {1'b0, 4'd9, 6'h1C, 32'h0000_005A},
    {1'b1, 4'd9, 6'h1C, 32'h0000_005A},
    {1'b1, 4'd6, 6'h30, 32'h0000_0001},  // R6 locked
    {1'b0, 4'd6, 6'h34, 32'h0000_0000},
    {1'b1, 4'd6, 6'h34, 32'h0000_00F6},  // R6 commit write blocked
    {1'b0, 4'd6, 6'h30, 32'h4C4F_434B},
    {1'b1, 4'd6, 6'h30, 32'h0000_0000},
    {1'b0, 4'd6, 6'h34, 32'h0000_00FF},
    {1'b1, 4'd6, 6'h34, 32'h0000_00FF},
    {1'b0, 4'd6, 6'h30, 32'h1234_5678},
    {1'b1, 4'd6, 6'h30, 32'h0000_0001},  // R6 relocked
    {1'b0, 4'd6, 6'h34, 32'h0000_0000},
    {1'b1, 4'd6, 6'h34, 32'h0000_00FF},
    {1'b0, 4'd7, 6'h04, 32'h0000_0000},
    {1'b1, 4'd7, 6'h04, 32'h0000_0000},  // R7 committed pins now writable
    {1'b0, 4'd8, 6'h00, 32'hFFFF_FF00},
    {1'b1, 4'd8, 6'h00, 32'h0000_0000},  // R8 upper bits dropped
    {1'b1, 4'd8, 6'h38, 32'h0000_0000},
    {1'b0, 4'd8, 6'h01, 32'h0000_00FF},  // R8 misaligned write
    {1'b1, 4'd8, 6'h00, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports and through reads
    check("R1 dir", 32'(pad_dir), 32'h00);
    check("R1 den", 32'(pad_den), 32'hFF);
    check("R1 afen", 32'(pad_afen), 32'h09);
    check("R1 pulls", 32'({pad_pu, pad_pd}), 32'h0);
    check("R1 drv", 32'({pad_drv2, pad_drv4, pad_drv8}), 32'hFF0000);
    check("R1 od/ana/slew", 32'({pad_od, pad_ana, pad_slew}), 32'h0);
    check("R1 fsel", pad_fsel, 32'h0);
    bus_read("R1 commit", 6'h34, 32'h0000_00F6);
    bus_read("R1 lock", 6'h30, 32'h0000_0001);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) begin
        bus_read($sformatf("R%0d vec %0d", VEC[i][41:38], i), VEC[i][37:32], VEC[i][31:0]);
      end else begin
        bus_write(VEC[i][37:32], VEC[i][31:0]);
      end
    end

    // R5 field layout at the port: pin 1 in bits [7:4], pin 7 in bits [31:28]
    check("R5 pin1", 32'(pad_fsel[7:4]), 32'h7);
    check("R5 pin7", 32'(pad_fsel[31:28]), 32'h1);

    // R4 slew only where 8 mA drive is selected (8 mA currently 8'h03)
    bus_write(6'h2C, 32'hFF);
    bus_read("R4 slew reg", 6'h2C, 32'hFF);
    check("R4 slew out", 32'(pad_slew), 32'h03);
    bus_write(6'h20, 32'h01);
    @(negedge clk);
    check("R3 drv8 cleared", 32'(pad_drv8), 32'h02);
    check("R4 slew follows drive", 32'(pad_slew), 32'h02);

    // R1 reset in mid-run restores lock and commit mask
    bus_write(6'h30, 32'h4C4F_434B);
    bus_write(6'h34, 32'hFF);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bus_read("R1 relock", 6'h30, 32'h1);
    bus_read("R1 commit restored", 6'h34, 32'hF6);
    check("R1 afen restored", 32'(pad_afen), 32'h09);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule